// File: doc/BRIEF.md
# Audio Frame Step Sequencer

This block supplies the slow timing strobes for a sound generator. A down-counting divider runs on the master clock and produces one tick per `DIV_PERIOD` cycles. Each tick advances a looping step sequencer. On selected steps the sequencer emits a one-cycle quarter-rate strobe, which drives envelope and linear-counter units, and a half-rate strobe, which drives length-counter and sweep units. In its four-step mode the sequencer also raises an interrupt flag on the final step. The flag appears on an active-high `irq` output.

Software selects the sequence length and the interrupt inhibit through a write-only control byte. Any write restarts the sequence and reloads the divider. A write that selects the five-step sequence also performs the first step's strobes at once. A separate acknowledge input clears the interrupt flag.

Top module: `aud_frame_seq`

## Requirements
- R1: Control bit 7 selects the sequence: 0 gives the four-step sequence and 1 gives the five-step sequence. Control bit 6 is the interrupt inhibit.
- R2: In four-step mode, every one of the four steps emits a quarter strobe, and only the second and fourth steps also emit a half strobe.
- R3: In five-step mode, steps one to four emit a quarter strobe and only steps one and three emit a half strobe. Step five emits nothing, and the interrupt flag is never set in this mode.
- R4: Step actions appear on the outputs once every `DIV_PERIOD` clock cycles. The first action after a control write or a reset appears `DIV_PERIOD` cycles after that clock edge.
- R5: A control write restarts the sequence at step one and reloads the divider. When the write selects five-step mode, the quarter and half strobes are both high in the cycle that follows the write edge, and the next action is step two.
- R6: In four-step mode, the fourth step sets the interrupt flag when the inhibit is 0. `irq` equals the flag, and the flag stays set until something clears it.
- R7: A control write with bit 6 = 1 clears the flag at once and stops it from being set. A write with bit 6 = 0 leaves the flag unchanged.
- R8: `irq_ack` high at a clock edge clears the flag. If the flag is set and acknowledged at the same edge, the flag ends up set.
- R9: After a synchronous reset, the block is in four-step mode with the inhibit at 0, the flag is clear, the strobes are low and the sequence waits at step one.
- R10: The quarter and half strobes are one clock cycle wide and are low in every cycle that carries no step action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Strobe that writes the control byte |
| ctl_data | input | 8 | Control byte: bit 7 selects the mode, bit 6 is the inhibit |
| irq_ack | input | 1 | Clears the interrupt flag |
| qtr_pulse | output | 1 | Quarter-rate step strobe |
| half_pulse | output | 1 | Half-rate step strobe |
| irq | output | 1 | Interrupt flag, active high |

## Verification
The bench runs a short divider period and compares every output in every cycle against an independent step model. This catches a sequencer that swaps the half-strobe steps between the two modes, or one that raises strobes off the tick grid. Writes issued in the middle of a sequence check that the divider reload and the step restart really take effect. A design that skips the immediate five-step action shows up as missing strobes right after the write. One test acknowledges the flag on the exact edge where step four sets it, which exposes a design where the clear wins. Other tests check that an inhibit write clears a pending flag and that a write with the inhibit at 0 leaves the flag alone, which exposes a design that clears on every write.

// File: rtl/aud_frame_seq_pkg.sv
package aud_frame_seq_pkg;

  localparam int CTL_W        = 8;
  localparam int CTL_MODE_BIT = 7;
  localparam int CTL_INH_BIT  = 6;
  localparam int STEP_W       = 3;

  typedef enum logic {
    SEQ_FOUR = 1'b0,
    SEQ_FIVE = 1'b1
  } seq_mode_e;

  typedef struct packed {
    logic half;
    logic qtr;
  } step_act_t;

  // Index of the final step (steps are numbered from 0 here).
  function automatic logic [STEP_W-1:0] last_step(input seq_mode_e m);
    return (m == SEQ_FIVE) ? STEP_W'(4) : STEP_W'(3);
  endfunction

  // Strobes produced by a given step in a given mode.
  function automatic step_act_t step_actions(input seq_mode_e m,
                                             input logic [STEP_W-1:0] s);
    step_act_t a;
    a.qtr  = (s <= STEP_W'(3));
    if (m == SEQ_FOUR) a.half = (s == STEP_W'(1)) || (s == STEP_W'(3));
    else               a.half = (s == STEP_W'(0)) || (s == STEP_W'(2));
    return a;
  endfunction

endpackage

// File: rtl/afs_divider.sv
module afs_divider #(
  parameter int DIV_PERIOD = 89490
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  output logic tick
);
  localparam int CW = (DIV_PERIOD > 1) ? $clog2(DIV_PERIOD) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DIV_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == '0) && !reload;

  always_ff @(posedge clk) begin
    if (rst || reload || cnt_q == '0) cnt_q <= LOAD;
    else                               cnt_q <= cnt_q - 1'b1;
  end

  // R4: a write always restarts the full divider period
  p_reload_full_r4: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt_q == LOAD));

  // R4: no tick can appear in the cycle right after a reload
  generate
    if (DIV_PERIOD > 1) begin : g_gap
      p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        reload |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/afs_stepper.sv
module afs_stepper
  import aud_frame_seq_pkg::*;
#(
  parameter int DIV_PERIOD = 89490
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic             tick,
  output logic             qtr_o,
  output logic             half_o,
  output logic             set_req_o,
  output seq_mode_e        mode_o
);
  seq_mode_e         mode_q;
  logic              inh_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_nxt;
  step_act_t         act_now;
  step_act_t         act_first5;
  logic              qtr_q, half_q;

  always_comb begin
    act_now    = step_actions(mode_q, step_q);
    act_first5 = step_actions(SEQ_FIVE, '0);
    step_nxt   = (step_q == last_step(mode_q)) ? '0 : step_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SEQ_FOUR;
      inh_q  <= 1'b0;
      step_q <= '0;
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
    end else if (ctl_wr) begin
      mode_q <= seq_mode_e'(ctl_data[CTL_MODE_BIT]);
      inh_q  <= ctl_data[CTL_INH_BIT];
      if (ctl_data[CTL_MODE_BIT]) begin
        step_q <= STEP_W'(1);
        qtr_q  <= act_first5.qtr;
        half_q <= act_first5.half;
      end else begin
        step_q <= '0;
        qtr_q  <= 1'b0;
        half_q <= 1'b0;
      end
    end else if (tick) begin
      step_q <= step_nxt;
      qtr_q  <= act_now.qtr;
      half_q <= act_now.half;
    end else begin
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
    end
  end

  assign qtr_o     = qtr_q;
  assign half_o    = half_q;
  assign mode_o    = mode_q;
  assign set_req_o = tick && (mode_q == SEQ_FOUR) &&
                     (step_q == last_step(SEQ_FOUR)) && !inh_q;

  // R2/R3: every half-strobe step is also a quarter-strobe step
  p_half_in_qtr_r2: assert property (@(posedge clk) disable iff (rst)
    half_o |-> qtr_o);

  // R5: selecting five-step mode fires step one at once
  p_first_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_data[CTL_MODE_BIT]) |=> (qtr_o && half_o));

  // R1: the mode follows bit 7 of the written byte
  p_mode_sel_r1: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (mode_o == seq_mode_e'($past(ctl_data[CTL_MODE_BIT]))));

  // R10: strobes last a single cycle
  generate
    if (DIV_PERIOD > 1) begin : g_width
      p_pulse_width_r10: assert property (@(posedge clk) disable iff (rst)
        (qtr_o && !ctl_wr) |=> !qtr_o);
    end
  endgenerate

endmodule

// File: rtl/afs_irq_flag.sv
module afs_irq_flag
  import aud_frame_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_req,
  input  logic      inh_clear,
  input  logic      ack,
  input  seq_mode_e mode,
  output logic      flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)            flag_q <= 1'b0;
    else if (set_req)   flag_q <= 1'b1;
    else if (inh_clear) flag_q <= 1'b0;
    else if (ack)       flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R8: a set wins over an acknowledge at the same edge
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set_req |=> flag_o);

  // R8: an acknowledge with no set clears the flag
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && !set_req) |=> !flag_o);

  // R7: an inhibit write clears the flag
  p_inh_clears_r7: assert property (@(posedge clk) disable iff (rst)
    inh_clear |=> !flag_o);

  // R3: five-step mode never raises the flag
  p_no_set_five_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == SEQ_FIVE && !flag_o) |=> !flag_o);

endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq
  import aud_frame_seq_pkg::*;
#(
  parameter int DIV_PERIOD = 89490
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic             irq_ack,
  output logic             qtr_pulse,
  output logic             half_pulse,
  output logic             irq
);
  logic      tick;
  logic      set_req;
  seq_mode_e mode;

  afs_divider #(.DIV_PERIOD(DIV_PERIOD)) u_div (
    .clk    (clk),
    .rst    (rst),
    .reload (ctl_wr),
    .tick   (tick)
  );

  afs_stepper #(.DIV_PERIOD(DIV_PERIOD)) u_step (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_data  (ctl_data),
    .tick      (tick),
    .qtr_o     (qtr_pulse),
    .half_o    (half_pulse),
    .set_req_o (set_req),
    .mode_o    (mode)
  );

  afs_irq_flag u_irq (
    .clk       (clk),
    .rst       (rst),
    .set_req   (set_req),
    .inh_clear (ctl_wr && ctl_data[CTL_INH_BIT]),
    .ack       (irq_ack),
    .mode      (mode),
    .flag_o    (irq)
  );

  // R9: out of reset everything is quiet
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!irq && !qtr_pulse && !half_pulse));

endmodule

// File: tb/test_aud_frame_seq.sv
module test_aud_frame_seq;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = '0;
  logic       irq_ack = 1'b0;
  logic       qtr_pulse, half_pulse, irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  exp_irq = 1'b0;

  always #2 clk = ~clk;

  aud_frame_seq #(.DIV_PERIOD(P)) i_aud_frame_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .irq_ack(irq_ack), .qtr_pulse(qtr_pulse), .half_pulse(half_pulse),
    .irq(irq)
  );

  task automatic chk(input logic act, input logic exp, input string req,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s @%0t: got %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    exp_irq = 1'b0;
    chk(qtr_pulse, 1'b0, "R9", "qtr after reset");
    chk(half_pulse, 1'b0, "R9", "half after reset");
    chk(irq, 1'b0, "R9", "irq after reset");
  endtask

  // Write the control byte; outputs are checked right after the edge (R5, R7).
  task automatic do_write(input logic [7:0] d);
    ctl_wr = 1'b1;
    ctl_data = d;
    @(posedge clk);
    #1 ctl_wr = 1'b0;
    if (d[6]) exp_irq = 1'b0;
    chk(qtr_pulse, d[7], "R5", "qtr at write");
    chk(half_pulse, d[7], "R5", "half at write");
    chk(irq, exp_irq, "R7", "irq at write");
  endtask

  // Run n cycles after a write or reset and compare every cycle with the step model.
  task automatic run_win(input bit m5, input bit inh, input int n, input int ack_edge);
    for (int k = 1; k <= n; k++) begin
      bit eq, eh, setev;
      int s;
      irq_ack = (k == ack_edge);
      @(posedge clk);
      #1 irq_ack = 1'b0;
      eq = 1'b0; eh = 1'b0; setev = 1'b0;
      if (k % P == 0) begin
        if (!m5) begin
          s = ((k / P - 1) % 4) + 1;
          eq = 1'b1;
          eh = (s == 2) || (s == 4);
          setev = (s == 4) && !inh;
        end else begin
          s = ((k / P) % 5) + 1;
          eq = (s <= 4);
          eh = (s == 1) || (s == 3);
        end
      end
      if (setev) exp_irq = 1'b1;
      else if (k == ack_edge) exp_irq = 1'b0;
      chk(qtr_pulse, eq, m5 ? "R3/R4/R10" : "R2/R4/R10", "qtr");
      chk(half_pulse, eh, m5 ? "R3" : "R2", "half");
      chk(irq, exp_irq, m5 ? "R3/R8" : "R6/R8", "irq");
    end
  endtask

  task automatic t_reset_then_four();   // R9, R2, R6
    do_reset();
    run_win(1'b0, 1'b0, 8 * P, 0);
  endtask

  task automatic t_ack();               // R8
    run_win(1'b0, 1'b0, 2 * P, 3);
    chk(irq, 1'b0, "R8", "irq after ack");
  endtask

  task automatic t_set_and_ack();       // R8: set wins
    do_write(8'h00);
    run_win(1'b0, 1'b0, 4 * P, 4 * P);
    chk(irq, 1'b1, "R8", "set beats ack");
  endtask

  task automatic t_write_keeps_flag();  // R7: bit 6 = 0 leaves flag set
    do_write(8'h00);
    chk(irq, 1'b1, "R7", "flag kept by plain write");
    run_win(1'b0, 1'b0, P + 3, 0);
  endtask

  task automatic t_inhibit();           // R7: clears and blocks setting
    do_write(8'h40);
    chk(irq, 1'b0, "R7", "flag cleared by inhibit");
    run_win(1'b0, 1'b1, 8 * P, 0);
  endtask

  task automatic t_five();              // R1, R3, R5
    do_write(8'h80);
    run_win(1'b1, 1'b0, 10 * P, 0);
    do_write(8'h80);                    // restart mid sequence
    run_win(1'b1, 1'b0, 2 * P + 3, 0);
    do_write(8'hC0);
    run_win(1'b1, 1'b1, 6 * P, 0);
  endtask

  task automatic t_restart_four();      // R5, R4: restart from five-step into four-step
    do_write(8'h80);
    run_win(1'b1, 1'b0, P + 2, 0);
    do_write(8'h00);
    run_win(1'b0, 1'b0, 5 * P, 0);
    do_write(8'h00);
    run_win(1'b0, 1'b0, 3, 1);
  endtask

  initial begin
    t_reset_then_four();
    t_ack();
    t_set_and_ack();
    t_write_keeps_flag();
    t_inhibit();
    t_five();
    t_restart_four();
    do_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule